// File: doc/BRIEF.md
# Sign Bit Reduction Decoder

This block sits on the receiving end of a data bus that carries words in sign bit reduction form. In that form only one sign bit of a two's complement value is kept. A flag bit sits above an N-bit payload, and every redundant sign-extension bit is cleared to zero. When the value changes sign, only the flag and the kept bit toggle on the bus, not the whole run of extension bits. The decoder turns each (N+1)-bit bus word back into an ordinary N-bit two's complement word.

With the flag clear, the payload is already the value. With the flag set, the highest set payload bit is the kept sign bit. The decoder fills every payload position above that bit with ones. A set flag with a zero payload cannot come from a legal encoder. Such a word yields the most negative value and raises a sticky error flag. The result is registered, and its valid flag trails the input strobe by one clock.

Top module: `sbr_decoder`

## Requirements
- R1: A synchronous active-high reset drives outValid, outData and errSticky to 0, whatever the input strobe and code are during reset.
- R2: outValid equals the value inValid had in the previous clock cycle, so a result appears exactly one cycle after its word is presented.
- R3: For a valid word whose top bit (the flag, bit N) is 0, outData equals the low N bits of the word unchanged.
- R4: For a valid word with the flag at 1 and a nonzero payload, outData keeps every payload bit up to and including the highest set payload bit, and every bit above that position is 1.
- R5: With N = 8, the word 1_00010100 decodes to 11110100 and the word 0_00010110 decodes to 00010110.
- R6: A valid word with the flag at 1 and an all-zero payload decodes to the most negative value (only bit N-1 set) and sets errSticky in the same cycle as the result. errSticky is raised by nothing else.
- R7: Once set, errSticky stays at 1 through any later words, legal or not, until reset.
- R8: While inValid is 0, outData holds its last value and errSticky does not change, even if an illegal word is on the bus.
- R9: Every N-bit value, encoded with its minimum sign extension (flag set and extension bits cleared for negative values, plain value for non-negative ones), decodes back to itself. This covers -1 (word 1_00000001), 0, and the most negative value (word 1_10000000 for N = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Strobe: inCode holds a word this cycle |
| inCode | input | DATA_W+1 | Encoded word: flag in the top bit, payload below |
| outValid | output | 1 | outData holds a fresh result |
| outData | output | DATA_W | Rebuilt two's complement value, registered |
| errSticky | output | 1 | Set by an illegal word, cleared only by reset |

## Verification
The hardest state to reach from the ports is an illegal word hidden behind a low strobe. It must neither raise the error flag nor disturb the held result, and it is only meaningful once outData already holds a known nonzero value. The bench first decodes a known word. It then drops the strobe while the all-zero-payload flagged word sits on the bus for two cycles, and checks both outputs. Afterwards it sends the illegal word with the strobe high and streams legal words behind it to show that the flag persists. Every bus word is swept back to back, and every N-bit value is swept through a bench-side encoder.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Strobes issued by the control side to the datapath each cycle.
  typedef struct packed {
    logic clear;    // synchronous clear of registered state
    logic capture;  // load a new result this cycle
    logic pickMin;  // substitute the most negative value
  } sbrStrobes_t;

endpackage

// File: rtl/sbr_fill_mask.sv
// Marks every payload position that has no set bit at or above it.
// The chain runs from the top bit down, one AND per position.
module sbr_fill_mask #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] payload,
  output logic [WIDTH-1:0] fillMask,
  output logic             anySet
);

  logic [WIDTH:0] noneFromHere;

  assign noneFromHere[WIDTH] = 1'b1;

  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_chain
    assign noneFromHere[i] = noneFromHere[i+1] & ~payload[i];
    assign fillMask[i]     = noneFromHere[i];
  end

  assign anySet = ~noneFromHere[0];

endmodule

// File: rtl/sbr_datapath.sv
// Rebuilds the sign extension and holds the registered result.
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  sbrStrobes_t       strobes,
  input  logic [DATA_W:0]   inCode,
  output logic              illegalCode,
  output logic [DATA_W-1:0] outData
);

  localparam logic [DATA_W-1:0] MostNeg = {1'b1, {(DATA_W-1){1'b0}}};

  logic              signFlag;
  logic [DATA_W-1:0] payload;
  logic [DATA_W-1:0] fillMask;
  logic              anySet;
  logic [DATA_W-1:0] rebuilt;
  logic [DATA_W-1:0] nextData;

  assign signFlag = inCode[DATA_W];
  assign payload  = inCode[DATA_W-1:0];

  sbr_fill_mask #(.WIDTH(DATA_W)) u_mask (
    .payload (payload),
    .fillMask(fillMask),
    .anySet  (anySet)
  );

  assign illegalCode = signFlag & ~anySet;

  always_comb begin
    if (signFlag) rebuilt = payload | fillMask;
    else          rebuilt = payload;
    nextData = strobes.pickMin ? MostNeg : rebuilt;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)        outData <= '0;
    else if (strobes.capture) outData <= nextData;
  end

endmodule

// File: rtl/sbr_ctrl.sv
// Valid pipeline, sticky error flag and strobe generation.
module sbr_ctrl
  import sbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        illegalCode,
  output sbrStrobes_t strobes,
  output logic        outValid,
  output logic        errSticky
);

  always_comb begin
    strobes.clear   = rst;
    strobes.capture = inValid & ~rst;
    strobes.pickMin = inValid & illegalCode;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      outValid  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      outValid <= inValid;
      if (strobes.capture && strobes.pickMin) errSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/sbr_decoder.sv
// Thin top: control and datapath joined by a strobe struct.
module sbr_decoder
  import sbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W:0]   inCode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              errSticky
);

  sbrStrobes_t strobes;
  logic        illegalCode;

  sbr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .illegalCode(illegalCode),
    .strobes    (strobes),
    .outValid   (outValid),
    .errSticky  (errSticky)
  );

  sbr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .inCode     (inCode),
    .illegalCode(illegalCode),
    .outData    (outData)
  );

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W:0]   inCode,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              errSticky
);

  localparam logic [DATA_W:0]   BadWord = {1'b1, {DATA_W{1'b0}}};
  localparam logic [DATA_W-1:0] MostNeg = {1'b1, {(DATA_W-1){1'b0}}};

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R2
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R2
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst) (inValid && !inCode[DATA_W]) |=> outData == $past(inCode[DATA_W-1:0])); // R3
  AST_NEG_TOP: assert property (@(posedge clk) disable iff (rst) (inValid && inCode[DATA_W]) |=> outData[DATA_W-1]); // R4
  AST_ILLEGAL_MIN: assert property (@(posedge clk) disable iff (rst) (inValid && inCode == BadWord) |=> (errSticky && outData == MostNeg)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(errSticky) |-> $past(inValid && inCode == BadWord)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) errSticky |=> errSticky); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst) !inValid |=> $stable(outData)); // R8
  AST_HOLD_ERR: assert property (@(posedge clk) disable iff (rst) !inValid |=> $stable(errSticky)); // R8

endmodule

bind sbr_decoder sbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inCode   (inCode),
  .outValid (outValid),
  .outData  (outData),
  .errSticky(errSticky)
);

// File: tb/sim_sbr_decoder.sv
module sim_sbr_decoder;

  localparam int N = 8;
  localparam int MASK = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [N:0]   inCode = '0;
  logic         outValid;
  logic [N-1:0] outData;
  logic         errSticky;

  int compared = 0;
  int mismatched = 0;

  sbr_decoder #(.DATA_W(N)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inCode(inCode),
    .outValid(outValid), .outData(outData), .errSticky(errSticky)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // Decode by arithmetic: payload minus the next power of two above it.
  function automatic int expDecode(input int code);
    int flag = (code >> N) & 1;
    int pay = code & MASK;
    int p = 1;
    if (flag == 0) return pay;
    if (pay == 0) return 1 << (N - 1);
    while (p <= pay) p = p * 2;
    return (pay - p) & MASK;
  endfunction

  // Minimum sign-extension encoding of a signed value.
  function automatic int encode(input int v);
    int m = 1;
    if (v >= 0) return v;
    while (v < -(1 << (m - 1))) m++;
    return (1 << N) | (v + (1 << m));
  endfunction

  // Present one word, then sample one cycle later away from the edge.
  task automatic sendWord(input int code);
    inValid = 1'b1;
    inCode = code[N:0];
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int held;
    // R1: reset dominates an illegal valid word.
    rst = 1'b1; inValid = 1'b1; inCode = 9'h100;
    repeat (3) @(negedge clk);
    check("R1 outValid", outValid, 0);
    check("R1 outData", outData, 0);
    check("R1 errSticky", errSticky, 0);
    rst = 1'b0; inValid = 1'b0; inCode = '0;
    @(negedge clk);
    check("R2 idle outValid", outValid, 0);

    // R3/R4: every legal bus word, streamed back to back.
    for (int c = 0; c < (2 << N); c++) begin
      if (c == (1 << N)) continue;
      sendWord(c);
      check("R2 outValid", outValid, 1);
      if (c < (1 << N)) check("R3 pass", outData, expDecode(c));
      else              check("R4 fill", outData, expDecode(c));
      check("R6 no err", errSticky, 0);
    end

    // R5: worked examples.
    sendWord(9'b100010100);
    check("R5 neg example", outData, 8'b11110100);
    sendWord(9'b000010110);
    check("R5 pos example", outData, 8'b00010110);
    held = 8'b00010110;

    // R8: illegal word on the bus with strobe low.
    inValid = 1'b0; inCode = 9'h100;
    @(negedge clk);
    check("R2 drop", outValid, 0);
    check("R8 hold data", outData, held);
    @(negedge clk);
    check("R8 hold data 2", outData, held);
    check("R8 no err", errSticky, 0);

    // R9: round trip of every value, then directed corners.
    for (int v = -(1 << (N - 1)); v < (1 << (N - 1)); v++) begin
      sendWord(encode(v));
      check("R9 round trip", outData, v & MASK);
    end
    sendWord(encode(-1));
    check("R9 minus one", outData, MASK);
    sendWord(9'h001 | (1 << N));
    check("R9 minus one word", outData, MASK);
    sendWord(encode(0));
    check("R9 zero", outData, 0);
    sendWord(encode(-(1 << (N - 1))));
    check("R9 most negative", outData, 1 << (N - 1));
    check("R9 no err", errSticky, 0);

    // R6: illegal word with strobe high.
    sendWord(1 << N);
    check("R6 min value", outData, 1 << (N - 1));
    check("R6 err set", errSticky, 1);

    // R7: later legal words keep the flag.
    sendWord(9'h005);
    check("R7 err kept", errSticky, 1);
    check("R3 after err", outData, 5);
    sendWord(9'h1F0);
    check("R7 err kept 2", errSticky, 1);
    check("R4 after err", outData, 8'hF0);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 err idle", errSticky, 1);

    // R1: reset clears the sticky flag.
    rst = 1'b1;
    @(negedge clk);
    check("R1 err cleared", errSticky, 0);
    check("R1 data cleared", outData, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule